// File: doc/BRIEF.md
# Multi-Level Priority Interrupt Controller

This block arbitrates among up to sixteen interrupt levels with fixed priorities, level 0 being the most urgent. Every level runs its own small state machine with four states: disarmed, armed, waiting and active. It also has an enable bit that decides whether a waiting level may be granted. Level 0 is wired to a front-panel switch. It can be neither disarmed nor disabled, so it always works.

Trigger events come from hardware trigger inputs, from the panel switch, and from a software trigger command on the direct-control write port. That port also arms, disarms, enables and disables any set of levels given as a bit mask. The block grants the most urgent waiting level only if that level outranks every level currently in service. It raises a request that carries the level number and its vector address. The processor answers with a one-cycle acknowledge, which makes the level active. That acknowledge stands in for saving status and the program address.

When a service routine returns, a clear pulse hands the most urgent active level back to the armed state. A service routine can trigger a lower level by software so that less urgent work runs later. A trigger that arrives while a level is active is kept, and the level becomes waiting again when it is cleared. One input holds back a parameterized group of counter levels as a whole.

Top module: `prio_intr_ctrl`

## Requirements
- R1: After synchronous reset, irq is low, levels 1 and up are disarmed and disabled, and level 0 is armed and enabled.
- R2: A trigger on an armed, enabled level makes it waiting on the next edge. With nothing else pending, irq rises one edge later with irq_level set to the level and irq_vec equal to VEC_BASE plus the level.
- R3: A trigger on a disarmed level has no effect, and arming the level later does not produce a request. Command code 2 (disarm) moves the levels in the mask to disarmed.
- R4: When several levels are waiting and enabled, the lowest-numbered one is requested.
- R5: A waiting level is requested only if its number is lower than that of every active level. A less urgent level waits until the active levels above it have been cleared.
- R6: A clear_lvl pulse returns the lowest-numbered active level to armed. If that level was triggered while active, including in the same cycle as the clear, it returns to waiting instead.
- R7: A disabled level that is triggered stays waiting without being requested. Command code 4 disables the levels in the mask. Command code 3 enables them, and the level is then requested.
- R8: Level 0 ignores the disarm and disable commands, and a pulse on panel_sw triggers it.
- R9: While cnt_inhibit is high, levels CNT_LO through CNT_HI are not requested, and levels outside that group still are. When cnt_inhibit falls, a waiting group level is requested on the next edge.
- R10: Once raised, irq stays high with a stable level until ack is sampled high. It drops on that edge, and the acknowledged level becomes active.
- R11: Command code 5 triggers the levels in the mask, and code 1 arms them. Commands take effect on the edge where cmd_valid is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | NUM_LEVELS | Hardware trigger events, one bit per level, one event per high cycle |
| panel_sw | input | 1 | Panel switch pulse that triggers level 0 |
| cmd_valid | input | 1 | Direct-control command strobe |
| cmd_op | input | 3 | Command code: 1 arm, 2 disarm, 3 enable, 4 disable, 5 trigger |
| cmd_mask | input | NUM_LEVELS | Levels addressed by the command |
| clear_lvl | input | 1 | Return-from-interrupt pulse that clears the most urgent active level |
| cnt_inhibit | input | 1 | Holds back the counter level group |
| ack | input | 1 | Acknowledge of the outstanding request |
| irq | output | 1 | Interrupt request |
| irq_level | output | LVL_W | Level number being requested |
| irq_vec | output | VEC_W | Vector address of the requested level |

## Verification
The collision that matters most is a trigger that reaches an active level in the same cycle as the clear that ends its service. The latched trigger must win, so the level comes back as waiting rather than armed. The bench drives trig_in and clear_lvl together for one cycle and then expects a fresh request for that level one edge later. A second overlap happens when a more urgent level is triggered while a less urgent one is in service. The bench checks that this preempts, and that the less urgent level stays blocked until both clears have arrived.

// File: rtl/pic_pkg.sv
// Package: shared state encoding and command codes for the interrupt controller.
// Assumes: command codes are 3 bits wide; unused codes are ignored.
package pic_pkg;

    typedef enum logic [1:0] {
        LV_DISARMED = 2'd0,
        LV_ARMED    = 2'd1,
        LV_WAITING  = 2'd2,
        LV_ACTIVE   = 2'd3
    } lvl_state_e;

    localparam logic [2:0] OP_ARM     = 3'd1;
    localparam logic [2:0] OP_DISARM  = 3'd2;
    localparam logic [2:0] OP_ENABLE  = 3'd3;
    localparam logic [2:0] OP_DISABLE = 3'd4;
    localparam logic [2:0] OP_TRIGGER = 3'd5;

endpackage

// File: rtl/pic_level.sv
// Module: state machine and enable bit of one interrupt level.
// Assumes: at most one of do_arm/do_disarm and one of do_en/do_dis per cycle
// (they come from one decoded command). Update order within a cycle:
// disarm/arm, then clear, then acknowledge, then trigger, so no trigger is lost.
// A panel level (IS_PANEL=1) resets armed and enabled and ignores disarm/disable.
module pic_level
    import pic_pkg::*;
#(
    parameter bit IS_PANEL = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       do_arm,
    input  logic       do_disarm,
    input  logic       do_en,
    input  logic       do_dis,
    input  logic       trig,
    input  logic       clr_hit,
    input  logic       ack_hit,
    output lvl_state_e state,
    output logic       enabled
);

    localparam lvl_state_e RST_STATE = IS_PANEL ? LV_ARMED : LV_DISARMED;

    lvl_state_e st_q, st_d;
    logic       pend_q, pend_d;
    logic       en_q;
    logic       eff_disarm;

    assign eff_disarm = do_disarm && !IS_PANEL;

    // Next state of the level: commands, clear, acknowledge and trigger in order.
    always_comb begin
        st_d   = st_q;
        pend_d = pend_q;
        if (eff_disarm) begin
            st_d   = LV_DISARMED;
            pend_d = 1'b0;
        end else if (do_arm) begin
            st_d   = LV_ARMED;
            pend_d = 1'b0;
        end
        if (clr_hit && st_d == LV_ACTIVE) begin
            st_d   = pend_d ? LV_WAITING : LV_ARMED;
            pend_d = 1'b0;
        end
        if (ack_hit && st_d == LV_WAITING) begin
            st_d = LV_ACTIVE;
        end
        if (trig) begin
            case (st_d)
                LV_ARMED:  st_d   = LV_WAITING;
                LV_ACTIVE: pend_d = 1'b1;
                default:   ;
            endcase
        end
    end

    // State and latched-trigger registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= RST_STATE;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
        end
    end

    // Enable bit; forced on for the panel level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= IS_PANEL;
        end else if (IS_PANEL) begin
            en_q <= 1'b1;
        end else if (do_en) begin
            en_q <= 1'b1;
        end else if (do_dis) begin
            en_q <= 1'b0;
        end
    end

    assign state   = st_q;
    assign enabled = en_q;

endmodule

// File: rtl/pic_ffs.sv
// Module: finds the lowest-numbered set bit of a vector (most urgent level).
// Assumes: WIDTH >= 2; idx is zero when found is low.
module pic_ffs #(
    parameter int WIDTH = 16,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/prio_intr_ctrl.sv
// Module: priority interrupt controller top. Decodes direct-control commands into
// per-level strobes, picks the most urgent grantable level and runs the single
// outstanding request/acknowledge handshake.
// Assumes: level 0 is the panel level; ack is a one-cycle pulse answering irq.
module prio_intr_ctrl
    import pic_pkg::*;
#(
    parameter int          NUM_LEVELS = 16,
    parameter int          VEC_W      = 16,
    parameter logic [15:0] VEC_BASE   = 16'h0050,
    parameter int          CNT_LO     = 2,
    parameter int          CNT_HI     = 5,
    localparam int         LVL_W      = $clog2(NUM_LEVELS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LEVELS-1:0] trig_in,
    input  logic                  panel_sw,
    input  logic                  cmd_valid,
    input  logic [2:0]            cmd_op,
    input  logic [NUM_LEVELS-1:0] cmd_mask,
    input  logic                  clear_lvl,
    input  logic                  cnt_inhibit,
    input  logic                  ack,
    output logic                  irq,
    output logic [LVL_W-1:0]      irq_level,
    output logic [VEC_W-1:0]      irq_vec
);

    function automatic logic [NUM_LEVELS-1:0] counter_group();
        logic [NUM_LEVELS-1:0] m;
        for (int i = 0; i < NUM_LEVELS; i++) begin
            m[i] = (i >= CNT_LO) && (i <= CNT_HI);
        end
        return m;
    endfunction

    localparam logic [NUM_LEVELS-1:0] CNT_MASK = counter_group();

    lvl_state_e            lvl_st [NUM_LEVELS];
    logic [NUM_LEVELS-1:0] en_vec, act_vec, wait_vec, elig_vec;
    logic [NUM_LEVELS-1:0] arm_v, disarm_v, en_v, dis_v, trig_v;
    logic [NUM_LEVELS-1:0] clr_v, ack_v;
    logic                  act_any, cand_any, cand_ok;
    logic [LVL_W-1:0]      act_idx, cand_idx;
    logic                  out_q;
    logic [LVL_W-1:0]      lvl_q;

    // Command decode into per-level strobe masks.
    always_comb begin
        arm_v    = (cmd_valid && cmd_op == OP_ARM)     ? cmd_mask : '0;
        disarm_v = (cmd_valid && cmd_op == OP_DISARM)  ? cmd_mask : '0;
        en_v     = (cmd_valid && cmd_op == OP_ENABLE)  ? cmd_mask : '0;
        dis_v    = (cmd_valid && cmd_op == OP_DISABLE) ? cmd_mask : '0;
        trig_v   = trig_in
                 | ((cmd_valid && cmd_op == OP_TRIGGER) ? cmd_mask : '0)
                 | NUM_LEVELS'(panel_sw);
    end

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
        assign clr_v[g] = clear_lvl && act_any && (act_idx == LVL_W'(g));
        assign ack_v[g] = out_q && ack && (lvl_q == LVL_W'(g));

        pic_level #(
            .IS_PANEL (g == 0)
        ) u_level (
            .clk       (clk),
            .rst_n     (rst_n),
            .do_arm    (arm_v[g]),
            .do_disarm (disarm_v[g]),
            .do_en     (en_v[g]),
            .do_dis    (dis_v[g]),
            .trig      (trig_v[g]),
            .clr_hit   (clr_v[g]),
            .ack_hit   (ack_v[g]),
            .state     (lvl_st[g]),
            .enabled   (en_vec[g])
        );

        assign act_vec[g]  = (lvl_st[g] == LV_ACTIVE);
        assign wait_vec[g] = (lvl_st[g] == LV_WAITING);
    end

    assign elig_vec = wait_vec & en_vec & ~(cnt_inhibit ? CNT_MASK : '0);

    pic_ffs #(.WIDTH(NUM_LEVELS)) u_act_ffs (
        .vec   (act_vec),
        .found (act_any),
        .idx   (act_idx)
    );

    pic_ffs #(.WIDTH(NUM_LEVELS)) u_cand_ffs (
        .vec   (elig_vec),
        .found (cand_any),
        .idx   (cand_idx)
    );

    assign cand_ok = cand_any && (!act_any || cand_idx < act_idx);

    // Request handshake: one outstanding request, dropped on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            lvl_q <= '0;
        end else if (out_q) begin
            if (ack) out_q <= 1'b0;
        end else if (cand_ok) begin
            out_q <= 1'b1;
            lvl_q <= cand_idx;
        end
    end

    assign irq       = out_q;
    assign irq_level = lvl_q;
    assign irq_vec   = VEC_W'(VEC_BASE) + VEC_W'(lvl_q);

endmodule

// File: rtl/prio_intr_ctrl_chk.sv
// Module: assertion checker bound to the interrupt controller top.
// Assumes: connected through the bind below; observes ports and level state.
module prio_intr_ctrl_chk
    import pic_pkg::*;
#(
    parameter int  NUM_LEVELS = 16,
    localparam int LVL_W      = $clog2(NUM_LEVELS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  irq,
    input logic                  ack,
    input logic [LVL_W-1:0]      irq_level,
    input logic [NUM_LEVELS-1:0] act_vec,
    input lvl_state_e            lvl0_st
);

    logic [NUM_LEVELS-1:0] upto_mask;

    // Levels at or above the requested priority.
    always_comb begin
        for (int i = 0; i < NUM_LEVELS; i++) begin
            upto_mask[i] = (i <= int'(irq_level));
        end
    end

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> (irq && $stable(irq_level)));

    // R10
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ack) |=> !irq);

    // R5
    outranks_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !$past(irq)) |-> ((act_vec & upto_mask) == '0));

    // R8
    panel_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl0_st != LV_DISARMED);

    // R10
    one_active_per_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ack) |=> ($countones(act_vec) >= 1));

endmodule

bind prio_intr_ctrl prio_intr_ctrl_chk #(
    .NUM_LEVELS (NUM_LEVELS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .ack       (ack),
    .irq_level (irq_level),
    .act_vec   (act_vec),
    .lvl0_st   (lvl_st[0])
);

// File: tb/prio_intr_ctrl_tb.sv
`timescale 1ns/1ps
module prio_intr_ctrl_tb;

    localparam int          N     = 16;
    localparam int          LW    = 4;
    localparam int          VW    = 16;
    localparam logic [15:0] VBASE = 16'h0050;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  trig_in;
    logic          panel_sw;
    logic          cmd_valid;
    logic [2:0]    cmd_op;
    logic [N-1:0]  cmd_mask;
    logic          clear_lvl;
    logic          cnt_inhibit;
    logic          ack;
    logic          irq;
    logic [LW-1:0] irq_level;
    logic [VW-1:0] irq_vec;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    prio_intr_ctrl #(
        .NUM_LEVELS (N),
        .VEC_W      (VW),
        .VEC_BASE   (VBASE),
        .CNT_LO     (2),
        .CNT_HI     (5)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_in     (trig_in),
        .panel_sw    (panel_sw),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_mask    (cmd_mask),
        .clear_lvl   (clear_lvl),
        .cnt_inhibit (cnt_inhibit),
        .ack         (ack),
        .irq         (irq),
        .irq_level   (irq_level),
        .irq_vec     (irq_vec)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_irq(input string req, input int lvl);
        chk(req, "irq", int'(irq), 1);
        chk(req, "irq_level", int'(irq_level), lvl);
        chk(req, "irq_vec", int'(irq_vec), int'(VBASE) + lvl);
    endtask

    task automatic expect_quiet(input string req);
        chk(req, "irq", int'(irq), 0);
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [N-1:0] mask);
        cmd_valid = 1'b1; cmd_op = op; cmd_mask = mask;
        tick();
        cmd_valid = 1'b0; cmd_op = '0; cmd_mask = '0;
    endtask

    task automatic hw_trig(input logic [N-1:0] mask);
        trig_in = mask;
        tick();
        trig_in = '0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    task automatic do_clr();
        clear_lvl = 1'b1;
        tick();
        clear_lvl = 1'b0;
    endtask

    // R1, R3: reset state and disarmed levels ignoring triggers.
    task automatic t_reset();
        expect_quiet("R1");
        hw_trig(16'hFFFE);
        idle(3);
        expect_quiet("R3");
        do_cmd(3'd1, 16'h0020);
        do_cmd(3'd3, 16'h0020);
        idle(2);
        expect_quiet("R3");
    endtask

    // R11, R2, R10, R6: software trigger, request timing, handshake, clear.
    task automatic t_soft();
        do_cmd(3'd5, 16'h0020);
        expect_quiet("R2");
        idle(1);
        expect_irq("R2", 5);
        idle(3);
        expect_irq("R10", 5);
        do_ack();
        expect_quiet("R10");
        idle(2);
        expect_quiet("R5");
        do_clr();
        idle(2);
        expect_quiet("R6");
        hw_trig(16'h0020);
        idle(1);
        expect_irq("R6", 5);
        do_ack();
        do_clr();
    endtask

    // R4, R5: priority among waiting levels and nesting.
    task automatic t_prio();
        do_cmd(3'd1, 16'h0208);
        do_cmd(3'd3, 16'h0208);
        hw_trig(16'h0208);
        idle(1);
        expect_irq("R4", 3);
        do_ack();
        idle(2);
        expect_quiet("R5");
        do_clr();
        idle(1);
        expect_irq("R5", 9);
        do_ack();
        hw_trig(16'h0008);
        idle(1);
        expect_irq("R5", 3);
        do_ack();
        do_clr();
        idle(2);
        expect_quiet("R5");
        do_clr();
        idle(2);
        expect_quiet("R6");
        hw_trig(16'h0200);
        idle(1);
        expect_irq("R6", 9);
        do_ack();
        do_clr();
    endtask

    // R6: trigger latched while active, also in the same cycle as the clear.
    task automatic t_latch();
        hw_trig(16'h0020);
        idle(1);
        expect_irq("R6", 5);
        do_ack();
        hw_trig(16'h0020);
        idle(2);
        expect_quiet("R6");
        do_clr();
        idle(1);
        expect_irq("R6", 5);
        do_ack();
        trig_in = 16'h0020;
        clear_lvl = 1'b1;
        tick();
        trig_in = '0;
        clear_lvl = 1'b0;
        idle(1);
        expect_irq("R6", 5);
        do_ack();
        do_clr();
        idle(2);
        expect_quiet("R6");
    endtask

    // R7, R3: disable and disarm commands.
    task automatic t_disable();
        do_cmd(3'd4, 16'h0020);
        hw_trig(16'h0020);
        idle(3);
        expect_quiet("R7");
        do_cmd(3'd3, 16'h0020);
        idle(1);
        expect_irq("R7", 5);
        do_ack();
        do_clr();
        do_cmd(3'd2, 16'h0020);
        hw_trig(16'h0020);
        do_cmd(3'd1, 16'h0020);
        idle(2);
        expect_quiet("R3");
    endtask

    // R8: panel level survives disable/disarm and answers the switch.
    task automatic t_panel();
        do_cmd(3'd4, 16'h0001);
        do_cmd(3'd2, 16'h0001);
        panel_sw = 1'b1;
        tick();
        panel_sw = 1'b0;
        idle(1);
        expect_irq("R8", 0);
        do_ack();
        do_clr();
        idle(2);
        expect_quiet("R8");
    endtask

    // R9: counter group held back as a whole.
    task automatic t_inhibit();
        cnt_inhibit = 1'b1;
        hw_trig(16'h0020);
        idle(3);
        expect_quiet("R9");
        hw_trig(16'h0200);
        idle(1);
        expect_irq("R9", 9);
        do_ack();
        do_clr();
        idle(2);
        expect_quiet("R9");
        cnt_inhibit = 1'b0;
        tick();
        expect_irq("R9", 5);
        do_ack();
        do_clr();
    endtask

    initial begin
        #(5.0 * 150000);
        n_errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; trig_in = '0; panel_sw = 1'b0; cmd_valid = 1'b0;
        cmd_op = '0; cmd_mask = '0; clear_lvl = 1'b0; cnt_inhibit = 1'b0; ack = 1'b0;
        idle(3);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_soft();
        t_prio();
        t_latch();
        t_disable();
        t_panel();
        t_inhibit();
        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule